// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and forwards the most urgent one to a processor. Software programs it through a byte-wide port with one address bit, giving an even and an odd register address. A short initialization sequence sets the vector base and the end-of-interrupt style. After that, command writes update the mask, retire in-service levels and choose which status register an even-address read returns.

Each input is edge-sensitive. A rising edge records a pending request. Priority is fixed, and input 0 is the most urgent. The interrupt output rises only when an unmasked pending request outranks every level that is already in service. A one-cycle acknowledge pulse moves the winning request into service and latches its 8-bit vector, which is the base plus the level number. If nothing is eligible at the acknowledge, the controller returns the level-7 vector and marks nothing as in service, so software can recognise a spurious interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the controller is uninitialized. Both reads return 0, `irq_out` stays low even when inputs rise, and it remains low until an initialization sequence completes.
- R2: An even-address write with bit 4 set starts initialization. It clears the pending, in-service and mask registers and selects the pending register for even reads. The next odd writes are taken as the vector base, then a cascade word, then a mode word. The cascade word is skipped when bit 1 of the start byte is set, and the mode word is expected only when bit 0 of the start byte is set. The odd write after the last expected word goes to the mask register.
- R3: The vector latched at an acknowledge is the base plus the index of the winning level, modulo 256. It appears on `irq_vec` in the cycle after the acknowledge and holds until the next acknowledge.
- R4: Once initialized, an odd-address write loads the mask, and an odd-address read returns it. A 1 bit keeps that level from raising `irq_out`, but its request is still recorded in the pending register.
- R5: Priority is fixed with level 0 highest. `irq_out` is high exactly when some unmasked pending level has a lower index than every in-service level.
- R6: A rising edge on an input sets its pending bit. A level that stays high does not set the bit again. An acknowledge clears the winner's pending bit and, in normal end-of-interrupt mode, sets its in-service bit.
- R7: An even write of 0x0B makes later even reads return the in-service register. An even write of 0x0A makes them return the pending register. The selection holds until it is changed.
- R8: An even write of 0x60+L, with L from 0 to 7, clears only in-service bit L.
- R9: An even write of 0x20 clears only the lowest-index set in-service bit.
- R10: When bit 1 of the mode word is 1 (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R11: An acknowledge with no eligible level returns the vector base+7 and leaves the in-service and pending registers unchanged.
- R12: Before initialization, odd writes and acknowledges have no effect. After initialization, even writes with bits 4 and 3 both clear and bits 7:5 other than 001 or 011 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 1 | Register address: 0 even, 1 odd |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_in | input | 8 | Interrupt request lines, edge-sensitive |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | One-cycle acknowledge pulse |
| irq_vec | output | 8 | Vector latched at the last acknowledge |

## Verification
A wrong pending, in-service or mask bit shows at the ports within one cycle. The register is visible through the even or odd read path, and `irq_out` responds combinationally to all three registers, so a stale in-service bit blocks lower levels immediately. A wrong winner or base shows in `irq_vec` in the cycle after the acknowledge. A wrong sequencer state shows only when the next odd write lands in the wrong register, so the bench reads the mask back after each initialization variant. The sweeps cover every request pattern and every mask value, so a fault in priority resolution cannot hide behind one particular combination.

// File: rtl/pic_pkg.sv
// Shared types and command codes for the priority interrupt controller.
// Assumes an 8-bit command byte; the field positions below are decoded by pic_cfg_seq.
package pic_pkg;
    typedef enum logic [2:0] {
        ST_UNINIT = 3'd0,
        ST_BASE   = 3'd1,
        ST_CASC   = 3'd2,
        ST_MODE   = 3'd3,
        ST_READY  = 3'd4
    } cfg_state_e;

    localparam logic [2:0] OP_EOI_LOWEST = 3'b001;
    localparam logic [2:0] OP_EOI_LEVEL  = 3'b011;
endpackage

// File: rtl/pic_cfg_seq.sv
// Programming sequencer: walks the initialization words, holds the vector base,
// the end-of-interrupt style and the read selection, and decodes command strobes.
// Assumes at most one bus write per cycle.
module pic_cfg_seq
    import pic_pkg::*;
#(
    parameter int NUM_LVL = 8,
    localparam int DW = NUM_LVL,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          ready_o,
    output logic [DW-1:0] base_o,
    output logic          aeoi_o,
    output logic          sel_isr_o,
    output logic          init_clr_o,
    output logic          mask_wr_o,
    output logic          eoi_lvl_o,
    output logic          eoi_low_o,
    output logic [LW-1:0] eoi_idx_o
);
    cfg_state_e state_q;
    logic       want_casc_q, want_mode_q;
    logic       start_w, cmd_w, sel_w;

    assign start_w = wr_en_i && !addr_i && wdata_i[4];
    assign cmd_w   = wr_en_i && !addr_i && (state_q == ST_READY) && (wdata_i[4:3] == 2'b00);
    assign sel_w   = wr_en_i && !addr_i && (state_q == ST_READY) && (wdata_i[4:3] == 2'b01) && wdata_i[1];

    // Sequencer state and programmed configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_UNINIT;
            want_casc_q <= 1'b0;
            want_mode_q <= 1'b0;
            base_o      <= '0;
            aeoi_o      <= 1'b0;
            sel_isr_o   <= 1'b0;
        end else if (start_w) begin
            state_q     <= ST_BASE;
            want_casc_q <= !wdata_i[1];
            want_mode_q <= wdata_i[0];
            aeoi_o      <= 1'b0;
            sel_isr_o   <= 1'b0;
        end else if (sel_w) begin
            sel_isr_o <= wdata_i[0];
        end else if (wr_en_i && addr_i) begin
            case (state_q)
                ST_BASE: begin
                    base_o  <= wdata_i;
                    state_q <= want_casc_q ? ST_CASC : (want_mode_q ? ST_MODE : ST_READY);
                end
                ST_CASC: state_q <= want_mode_q ? ST_MODE : ST_READY;
                ST_MODE: begin
                    aeoi_o  <= wdata_i[1];
                    state_q <= ST_READY;
                end
                default: ;
            endcase
        end
    end

    // Command strobes decoded from the current write.
    assign ready_o    = (state_q == ST_READY);
    assign init_clr_o = start_w;
    assign mask_wr_o  = wr_en_i && addr_i && (state_q == ST_READY);
    assign eoi_lvl_o  = cmd_w && (wdata_i[7:5] == OP_EOI_LEVEL);
    assign eoi_low_o  = cmd_w && (wdata_i[7:5] == OP_EOI_LOWEST);
    assign eoi_idx_o  = wdata_i[LW-1:0];

    a_r2_start_resets_select: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (state_q == ST_BASE) && !sel_isr_o && !aeoi_o);
    a_r2_mode_word_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i && !start_w && state_q == ST_MODE) |=> ready_o);
    a_r12_odd_ignored_uninit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i && state_q == ST_UNINIT) |=> (state_q == ST_UNINIT) && $stable(base_o));
endmodule

// File: rtl/pic_prio.sv
// Fixed-priority resolver: finds the lowest-index unmasked pending level and
// qualifies it against the lowest-index in-service level. Purely combinational.
module pic_prio #(
    parameter int NUM_LVL = 8,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] irr_i,
    input  logic [NUM_LVL-1:0] imr_i,
    input  logic [NUM_LVL-1:0] isr_i,
    output logic               win_vld_o,
    output logic [LW-1:0]      win_idx_o
);
    logic [NUM_LVL-1:0] cand;
    logic               req_hit, svc_hit;
    logic [LW-1:0]      req_idx, svc_idx;

    // Scan from the lowest priority upward so the lowest index is kept last.
    always_comb begin
        cand    = irr_i & ~imr_i;
        req_hit = 1'b0;
        svc_hit = 1'b0;
        req_idx = '0;
        svc_idx = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (cand[i]) begin
                req_hit = 1'b1;
                req_idx = LW'(i);
            end
            if (isr_i[i]) begin
                svc_hit = 1'b1;
                svc_idx = LW'(i);
            end
        end
    end

    assign win_vld_o = req_hit && (!svc_hit || (req_idx < svc_idx));
    assign win_idx_o = req_idx;
endmodule

// File: rtl/pic_state.sv
// Request, in-service and mask registers with per-line rising-edge capture.
// Assumes that init_clr, take and the end-of-interrupt strobes come from one write or acknowledge per cycle.
module pic_state #(
    parameter int NUM_LVL = 8,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_in_i,
    input  logic               init_clr_i,
    input  logic               mask_wr_i,
    input  logic [NUM_LVL-1:0] wdata_i,
    input  logic               take_i,
    input  logic               win_vld_i,
    input  logic [LW-1:0]      win_idx_i,
    input  logic               aeoi_i,
    input  logic               eoi_lvl_i,
    input  logic               eoi_low_i,
    input  logic [LW-1:0]      eoi_idx_i,
    output logic [NUM_LVL-1:0] irr_o,
    output logic [NUM_LVL-1:0] isr_o,
    output logic [NUM_LVL-1:0] imr_o
);
    logic [NUM_LVL-1:0] line_q, rise, win_bit, ack_clr, ack_set, eoi_clr, isr_lowest;

    // One rising-edge detector per input line.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (!rst_n) line_q[g] <= 1'b0;
            else        line_q[g] <= irq_in_i[g];
        end
        assign rise[g] = irq_in_i[g] && !line_q[g];
    end

    assign win_bit    = NUM_LVL'(1) << win_idx_i;
    assign ack_clr    = (take_i && win_vld_i) ? win_bit : '0;
    assign ack_set    = (take_i && win_vld_i && !aeoi_i) ? win_bit : '0;
    assign isr_lowest = isr_o & (~isr_o + NUM_LVL'(1));
    assign eoi_clr    = eoi_lvl_i ? (NUM_LVL'(1) << eoi_idx_i) : (eoi_low_i ? isr_lowest : '0);

    // Pending register: an edge sets a bit, and an acknowledge of that level clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr_i) irr_o <= '0;
        else                      irr_o <= (irr_o & ~ack_clr) | rise;
    end

    // In-service register: set by an acknowledge, cleared by end-of-interrupt commands.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr_i) isr_o <= '0;
        else                      isr_o <= (isr_o & ~eoi_clr) | ack_set;
    end

    // Mask register: loaded by an odd-address write once the controller is ready.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr_i) imr_o <= '0;
        else if (mask_wr_i)       imr_o <= wdata_i;
    end

    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr_i |=> (isr_o == '0) && (imr_o == '0));
    a_r6_ack_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && win_vld_i && !aeoi_i && !init_clr_i) |=> isr_o[$past(win_idx_i)]);
    a_r8_level_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_lvl_i && !take_i && !init_clr_i) |=> !isr_o[$past(eoi_idx_i)]);
    a_r10_auto_eoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && aeoi_i && !eoi_lvl_i && !eoi_low_i && !init_clr_i) |=> $stable(isr_o));
    a_r11_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !win_vld_i && !eoi_lvl_i && !eoi_low_i && !init_clr_i) |=> $stable(isr_o));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the eight-level priority interrupt controller: ties the sequencer,
// the register state and the resolver together, and latches the vector on acknowledge.
// Assumes irq_ack is a single-cycle pulse issued by the processor after it sees irq_out.
module prio_irq_ctrl #(
    parameter int NUM_LVL = 8,
    localparam int DW = NUM_LVL,
    localparam int LW = $clog2(NUM_LVL),
    localparam logic [LW-1:0] SPUR_LVL = LW'(NUM_LVL - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] irq_in,
    output logic          irq_out,
    input  logic          irq_ack,
    output logic [DW-1:0] irq_vec
);
    logic          ready, aeoi, sel_isr, init_clr, mask_wr, eoi_lvl, eoi_low, take, win_vld;
    logic [DW-1:0] base, irr, isr, imr;
    logic [LW-1:0] eoi_idx, win_idx;

    pic_cfg_seq #(.NUM_LVL(NUM_LVL)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .ready_o(ready), .base_o(base), .aeoi_o(aeoi), .sel_isr_o(sel_isr),
        .init_clr_o(init_clr), .mask_wr_o(mask_wr), .eoi_lvl_o(eoi_lvl),
        .eoi_low_o(eoi_low), .eoi_idx_o(eoi_idx)
    );

    pic_state #(.NUM_LVL(NUM_LVL)) u_state (
        .clk(clk), .rst_n(rst_n), .irq_in_i(irq_in), .init_clr_i(init_clr),
        .mask_wr_i(mask_wr), .wdata_i(bus_wdata), .take_i(take), .win_vld_i(win_vld),
        .win_idx_i(win_idx), .aeoi_i(aeoi), .eoi_lvl_i(eoi_lvl), .eoi_low_i(eoi_low),
        .eoi_idx_i(eoi_idx), .irr_o(irr), .isr_o(isr), .imr_o(imr)
    );

    pic_prio #(.NUM_LVL(NUM_LVL)) u_prio (
        .irr_i(irr), .imr_i(imr), .isr_i(isr), .win_vld_o(win_vld), .win_idx_o(win_idx)
    );

    assign take    = irq_ack && ready;
    assign irq_out = ready && win_vld;

    // Read multiplexer: odd returns the mask, even returns the selected status.
    assign bus_rdata = bus_addr ? imr : (sel_isr ? isr : irr);

    // Vector latch: base plus winner, or base plus the spurious level.
    always_ff @(posedge clk) begin
        if (!rst_n)    irq_vec <= '0;
        else if (take) irq_vec <= base + DW'(win_vld ? win_idx : SPUR_LVL);
    end

    a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !irq_out);
    a_r5_out_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irr & ~imr) != '0));
    a_r3_vector_value: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_vld) |=> (irq_vec == DW'($past(base) + DW'($past(win_idx)))));
    a_r11_spurious_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !win_vld) |=> (irq_vec == DW'($past(base) + DW'(SPUR_LVL))));
    a_r12_ack_ignored_uninit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !ready) |=> $stable(irq_vec));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0, irq_ack = 1'b0;
    logic [7:0] bus_wdata = '0, irq_in = '0;
    logic [7:0] bus_rdata, irq_vec;
    logic       irq_out;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_out(irq_out), .irq_ack(irq_ack), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic init_std(input logic [7:0] base, input logic [7:0] mode);
        wr(1'b0, 8'h11); wr(1'b1, base); wr(1'b1, 8'h04); wr(1'b1, mode);
    endtask

    function automatic int lowest_set(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) lowest_set = i;
        if (v == 0) lowest_set = 7;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd(1'b0, d); chk("R1 even read", d, 0);
        rd(1'b1, d); chk("R1 odd read", d, 0);
        chk("R1 irq_out reset", irq_out, 0);
        irq_in = 8'h08; step();
        chk("R1 irq_out uninit", irq_out, 0);
        // R12: odd write and acknowledge before initialization
        wr(1'b1, 8'h55);
        rd(1'b1, d); chk("R12 mask untouched uninit", d, 0);
        ack();
        chk("R12 vector untouched uninit", irq_vec, 0);
        irq_in = 8'h00; step();

        // R2: standard init clears captured requests
        init_std(8'h30, 8'h01);
        rd(1'b0, d); chk("R2 pending cleared", d, 0);
        rd(1'b1, d); chk("R2 mask cleared", d, 0);
        chk("R2 irq_out after init", irq_out, 0);

        // Level sweep: R3 R6 R7 R8
        for (int n = 0; n < 8; n++) begin
            irq_in = 8'(1 << n); step();
            rd(1'b0, d); chk("R6 edge sets pending", d, 1 << n);
            chk("R5 irq_out single", irq_out, 1);
            ack();
            chk("R3 vector", irq_vec, 8'h30 + n);
            wr(1'b0, 8'h0B);
            rd(1'b0, d); chk("R7 in-service select", d, 1 << n);
            wr(1'b0, 8'h0A);
            rd(1'b0, d); chk("R6 held level no re-set", d, 0);
            chk("R5 blocked by service", irq_out, 0);
            irq_in = 8'h00;
            wr(1'b0, 8'(8'h60 + n));
            wr(1'b0, 8'h0B);
            rd(1'b0, d); chk("R8 level eoi", d, 0);
            rd(1'b0, d); chk("R7 select persists", d, 0);
            wr(1'b0, 8'h0A);
        end

        // Nesting: R5 R9 R12
        irq_in = 8'h20; step(); ack();
        chk("R3 nest first vector", irq_vec, 8'h35);
        wr(1'b0, 8'h0B); wr(1'b0, 8'h40);
        rd(1'b0, d); chk("R12 ignored command", d, 8'h20);
        wr(1'b0, 8'h0A);
        irq_in = 8'h60; step();
        chk("R5 lower level blocked", irq_out, 0);
        irq_in = 8'h64; step();
        chk("R5 higher level passes", irq_out, 1);
        ack();
        chk("R3 nested vector", irq_vec, 8'h32);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R6 nested service", d, 8'h24);
        wr(1'b0, 8'h20);
        rd(1'b0, d); chk("R9 lowest eoi", d, 8'h20);
        chk("R5 still blocked", irq_out, 0);
        wr(1'b0, 8'h65);
        rd(1'b0, d); chk("R8 level eoi nested", d, 8'h00);
        chk("R5 released", irq_out, 1);
        ack();
        chk("R3 released vector", irq_vec, 8'h36);
        wr(1'b0, 8'h66); wr(1'b0, 8'h0A);
        irq_in = 8'h00; step();

        // Exhaustive request patterns: R5 R3 R9
        for (int p = 1; p < 256; p++) begin
            irq_in = 8'h00; step();
            init_std(8'h30, 8'h01);
            irq_in = 8'(p); step();
            chk("R5 any request raises", irq_out, 1);
            ack();
            chk("R5 priority winner", irq_vec, 8'h30 + lowest_set(8'(p)));
            chk("R5 rest blocked", irq_out, 0);
            wr(1'b0, 8'h20);
            chk("R9 eoi releases next", irq_out, (p & (p - 1)) != 0 ? 1 : 0);
        end

        // Exhaustive masks: R4
        for (int m = 0; m < 256; m++) begin
            irq_in = 8'h00; step();
            init_std(8'h30, 8'h01);
            wr(1'b1, 8'(m));
            irq_in = 8'hFF; step();
            rd(1'b1, d); chk("R4 mask readback", d, m);
            rd(1'b0, d); chk("R4 masked still pending", d, 8'hFF);
            chk("R4 irq_out vs mask", irq_out, (m != 255) ? 1 : 0);
            if (m != 255) begin
                ack();
                chk("R4 masked winner", irq_vec, 8'h30 + lowest_set(~8'(m)));
            end
        end

        // R10: automatic end-of-interrupt
        irq_in = 8'h00; step();
        init_std(8'h40, 8'h03);
        irq_in = 8'h10; step(); ack();
        chk("R10 vector", irq_vec, 8'h44);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R10 no service bit", d, 0);
        irq_in = 8'h50; step();
        chk("R10 lower level not blocked", irq_out, 1);
        ack();
        chk("R10 second vector", irq_vec, 8'h46);

        // R11: request vanishes before acknowledge
        irq_in = 8'h00; step();
        init_std(8'h30, 8'h01);
        irq_in = 8'h08; step();
        chk("R11 raised", irq_out, 1);
        wr(1'b1, 8'h08);
        chk("R11 withdrawn", irq_out, 0);
        ack();
        chk("R11 spurious vector", irq_vec, 8'h37);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R11 service unchanged", d, 0);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R11 pending unchanged", d, 8'h08);

        // R2: shortened sequences
        irq_in = 8'h00; step();
        wr(1'b0, 8'h13); wr(1'b1, 8'h50); wr(1'b1, 8'h01); wr(1'b1, 8'h0F);
        rd(1'b1, d); chk("R2 no cascade word", d, 8'h0F);
        irq_in = 8'h10; step(); ack();
        chk("R2 short base vector", irq_vec, 8'h54);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R2 normal eoi mode", d, 8'h10);
        irq_in = 8'h00; step();
        wr(1'b0, 8'h10); wr(1'b1, 8'h58); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
        rd(1'b1, d); chk("R2 no mode word", d, 8'h03);
        irq_in = 8'h07; step(); ack();
        chk("R2 masked levels skipped", irq_vec, 8'h5A);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R2 default normal eoi", d, 8'h04);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule